// File: doc/BRIEF.md
# Byte/Word Data Memory Access Unit

This block connects a 16-bit core to a data memory that is addressed in bytes but organised as 16-bit words made of two byte-wide halves. Both halves share one word index and each has its own write enable. The core gives a byte address, a size flag (byte or word), read and write strobes, and write data. The unit issues per-half write enables. Each read result is returned in the cycle after the access, on the low byte lane where a byte is concerned. The unit also flags word accesses to odd addresses as address-error traps.

Two helpers sit next to the data path. The first is a pointer post-increment that advances by the size of the access. The second is a byte-load merge that writes a loaded byte into the low half of a destination register value. The merge can keep the register's high byte, or replace it by zero-extension or sign-extension. Only the first part of the byte address space is backed by storage: reads beyond it return zero and writes beyond it are dropped. The backing store is an internal array, so the unit can be exercised on its own.

Top module: `byte_lane_access`

## Requirements
- R1: A word write (`accByte`=0) to an even, implemented address drives `memByteWe`=2'b11 and stores `wrData` whole; a later word read at that address gives the full word on `rdResult`, with `rdValid`=1, one clock after the access.
- R2: A byte write (`accByte`=1) enables only the half chosen by address bit 0 (`memByteWe`=2'b01 for bit 0 = 0, 2'b10 for bit 0 = 1), stores `wrData[7:0]` there and leaves the other byte of the word unchanged.
- R3: A byte read fetches the containing word and places the byte chosen by address bit 0 on `rdResult[7:0]`; with `extMode` 0 or 3 the upper byte of `rdResult` equals `dstOld[15:8]`.
- R4: A word write to an odd address asserts no write enable and leaves memory unchanged.
- R5: A word read from an odd address still completes: it returns the containing word (the address with bit 0 cleared) and sets `rdValid`.
- R6: Any odd-address word access, read or write, makes `trapPulse` high for exactly the one cycle after the access; `trapAddr` then holds the faulting address until the next fault. Byte accesses never trap.
- R7: `ptrNext` equals `ptrIn`+1 when `accByte`=1 and `ptrIn`+2 when `accByte`=0, modulo 2^16.
- R8: On byte reads, `extMode`=1 clears `rdResult[15:8]` and `extMode`=2 fills it with bit 7 of the loaded byte; word reads ignore `extMode`.
- R9: Addresses at or above 2*MEM_WORDS are unimplemented: reads there return 0x0000 as the fetched word, and writes there assert no enable and change no stored data.
- R10: While `rstN` is low and after its release, `rdResult`, `rdValid`, `trapPulse` and `trapAddr` are zero until an access occurs.
- R11: When `rdEn` and `wrEn` are both high, the write is carried out and no read result is produced (`rdValid` stays 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| accAddr | input | 16 | Effective byte address |
| accByte | input | 1 | 1 = byte access, 0 = word access |
| rdEn | input | 1 | Read strobe |
| wrEn | input | 1 | Write strobe (wins over rdEn) |
| wrData | input | 16 | Write data; byte writes use bits 7:0 |
| extMode | input | 2 | Byte-load handling: 0/3 merge, 1 zero-extend, 2 sign-extend |
| dstOld | input | 16 | Current destination register value for merging |
| ptrIn | input | 16 | Pointer before post-increment |
| ptrNext | output | 16 | Pointer after post-increment by access size |
| memByteWe | output | 2 | Per-half write enables issued this cycle (bit 1 = high byte) |
| rdResult | output | 16 | Registered read result |
| rdValid | output | 1 | rdResult holds a read completed on the previous edge |
| trapPulse | output | 1 | One-cycle address-error trap |
| trapAddr | output | 16 | Address of the most recent faulting access |

## Verification
The bench builds the unit with MEM_WORDS=64, which makes the implemented region 128 bytes. With this size every byte and every word address in that region can be written and read back in every extension mode, and every odd word address can be driven as a faulting read and as a faulting write. The small region also puts the unimplemented-address boundary right after the swept range. Addresses above it, up to 0xFFFE, can then be tested for ignored writes and zero reads, and index aliasing into the backed words can be ruled out.

// File: rtl/bla_pkg.sv
package bla_pkg;
  typedef enum logic [1:0] {
    EXT_KEEP  = 2'd0,
    EXT_ZERO  = 2'd1,
    EXT_SIGN  = 2'd2,
    EXT_KEEP2 = 2'd3
  } extSel_e;

  typedef struct packed {
    logic       doRead;
    logic       raiseTrap;
    logic [1:0] laneWe;
    logic       inRange;
    logic       hiLane;
  } accStrobe_t;
endpackage

// File: rtl/bla_ctrl.sv
module bla_ctrl
  import bla_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int MEM_WORDS = 512
) (
  input  logic [ADDR_W-1:0] accAddr,
  input  logic              accByte,
  input  logic              rdEn,
  input  logic              wrEn,
  output accStrobe_t        strobe
);
  localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(MEM_WORDS * 2);

  logic misalign;
  logic inRange;

  assign misalign = !accByte && accAddr[0];
  assign inRange  = {1'b0, accAddr} < LIMIT;

  always_comb begin
    strobe           = '0;
    strobe.doRead    = rdEn && !wrEn;
    strobe.raiseTrap = (rdEn || wrEn) && misalign;
    strobe.inRange   = inRange;
    strobe.hiLane    = accAddr[0];
    if (wrEn && inRange && !misalign) begin
      if (accByte) strobe.laneWe = accAddr[0] ? 2'b10 : 2'b01;
      else         strobe.laneWe = 2'b11;
    end
  end

  always_comb begin
    a_r2_byte_single_lane: assert (!accByte || $countones(strobe.laneWe) <= 1)
      else $error("byte access enabled both halves");
  end
endmodule

// File: rtl/bla_datapath.sv
module bla_datapath
  import bla_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int MEM_WORDS = 512
) (
  input  logic              clk,
  input  logic              rstN,
  input  accStrobe_t        strobe,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic              accByte,
  input  logic [15:0]       wrData,
  input  logic [1:0]        extMode,
  input  logic [15:0]       dstOld,
  input  logic [ADDR_W-1:0] ptrIn,
  output logic [ADDR_W-1:0] ptrNext,
  output logic [15:0]       rdResult,
  output logic              rdValid,
  output logic              trapPulse,
  output logic [ADDR_W-1:0] trapAddr
);
  localparam int IDX_W = $clog2(MEM_WORDS);

  logic [7:0] loBank [MEM_WORDS];
  logic [7:0] hiBank [MEM_WORDS];

  logic [IDX_W-1:0] wordIdx;
  logic [15:0]      fetched;
  logic [7:0]       picked;
  logic [15:0]      loadVal;

  assign wordIdx = accAddr[IDX_W:1];
  assign ptrNext = ptrIn + (accByte ? ADDR_W'(1) : ADDR_W'(2));

  always_ff @(posedge clk) begin
    if (strobe.laneWe[0]) loBank[wordIdx] <= wrData[7:0];
    if (strobe.laneWe[1]) hiBank[wordIdx] <= accByte ? wrData[7:0] : wrData[15:8];
  end

  assign fetched = strobe.inRange ? {hiBank[wordIdx], loBank[wordIdx]} : 16'h0000;
  assign picked  = strobe.hiLane ? fetched[15:8] : fetched[7:0];

  always_comb begin
    if (!accByte) loadVal = fetched;
    else begin
      case (extSel_e'(extMode))
        EXT_ZERO: loadVal = {8'h00, picked};
        EXT_SIGN: loadVal = {{8{picked[7]}}, picked};
        default:  loadVal = {dstOld[15:8], picked};
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdResult  <= '0;
      rdValid   <= 1'b0;
      trapPulse <= 1'b0;
      trapAddr  <= '0;
    end else begin
      rdValid   <= strobe.doRead;
      trapPulse <= strobe.raiseTrap;
      if (strobe.doRead)    rdResult <= loadVal;
      if (strobe.raiseTrap) trapAddr <= accAddr;
    end
  end

  a_r6_trap_addr_hold: assert property (@(posedge clk) disable iff (!rstN)
    !trapPulse |-> $stable(trapAddr));
endmodule

// File: rtl/byte_lane_access.sv
module byte_lane_access
  import bla_pkg::*;
#(
  parameter int MEM_WORDS = 512
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [15:0] accAddr,
  input  logic        accByte,
  input  logic        rdEn,
  input  logic        wrEn,
  input  logic [15:0] wrData,
  input  logic [1:0]  extMode,
  input  logic [15:0] dstOld,
  input  logic [15:0] ptrIn,
  output logic [15:0] ptrNext,
  output logic [1:0]  memByteWe,
  output logic [15:0] rdResult,
  output logic        rdValid,
  output logic        trapPulse,
  output logic [15:0] trapAddr
);
  localparam int ADDR_W = 16;
  localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(MEM_WORDS * 2);

  accStrobe_t strobe;

  bla_ctrl #(.ADDR_W(ADDR_W), .MEM_WORDS(MEM_WORDS)) u_ctrl (
    .accAddr(accAddr), .accByte(accByte), .rdEn(rdEn), .wrEn(wrEn), .strobe(strobe)
  );

  bla_datapath #(.ADDR_W(ADDR_W), .MEM_WORDS(MEM_WORDS)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .accAddr(accAddr), .accByte(accByte),
    .wrData(wrData), .extMode(extMode), .dstOld(dstOld), .ptrIn(ptrIn),
    .ptrNext(ptrNext), .rdResult(rdResult), .rdValid(rdValid),
    .trapPulse(trapPulse), .trapAddr(trapAddr)
  );

  assign memByteWe = strobe.laneWe;

  a_r4_no_misaligned_we: assert property (@(posedge clk) disable iff (!rstN)
    (!accByte && accAddr[0]) |-> memByteWe == 2'b00);

  a_r6_trap_cause: assert property (@(posedge clk) disable iff (!rstN)
    trapPulse |-> $past((rdEn || wrEn) && !accByte && accAddr[0]));

  a_r6_trap_addr: assert property (@(posedge clk) disable iff (!rstN)
    trapPulse |-> trapAddr == $past(accAddr));

  a_r11_write_wins: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> $past(rdEn && !wrEn));

  a_r9_unimpl_zero: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !wrEn && !accByte && ({1'b0, accAddr} >= LIMIT)) |=> rdResult == 16'h0000);
endmodule

// File: tb/byte_lane_access_tb.sv
module byte_lane_access_tb;
  localparam int MEMW = 64;
  localparam int LIM  = 2 * MEMW;

  logic        clk = 1'b0;
  logic        rstN;
  logic [15:0] accAddr, wrData, dstOld, ptrIn;
  logic        accByte, rdEn, wrEn;
  logic [1:0]  extMode;
  logic [15:0] ptrNext, rdResult, trapAddr;
  logic [1:0]  memByteWe;
  logic        rdValid, trapPulse;

  int checks = 0;
  int errors = 0;
  logic [7:0] shadow [LIM];

  always #4 clk = ~clk;

  byte_lane_access #(.MEM_WORDS(MEMW)) u_dut (
    .clk(clk), .rstN(rstN), .accAddr(accAddr), .accByte(accByte), .rdEn(rdEn),
    .wrEn(wrEn), .wrData(wrData), .extMode(extMode), .dstOld(dstOld), .ptrIn(ptrIn),
    .ptrNext(ptrNext), .memByteWe(memByteWe), .rdResult(rdResult), .rdValid(rdValid),
    .trapPulse(trapPulse), .trapAddr(trapAddr)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [15:0] a, input logic b, input logic rd, input logic wr,
                       input logic [15:0] d, input logic [1:0] e, input logic [15:0] old);
    @(negedge clk);
    accAddr = a; accByte = b; rdEn = rd; wrEn = wr; wrData = d; extMode = e; dstOld = old;
    #1;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  function automatic logic [15:0] expWord(input int a);
    int e;
    e = a & ~1;
    if (a < LIM) return {shadow[e + 1], shadow[e]};
    return 16'h0000;
  endfunction

  function automatic logic [15:0] expByte(input int a, input logic [1:0] e, input logic [15:0] old);
    logic [7:0] s;
    s = (a < LIM) ? shadow[a] : 8'h00;
    case (e)
      2'd1:    return {8'h00, s};
      2'd2:    return {{8{s[7]}}, s};
      default: return {old[15:8], s};
    endcase
  endfunction

  task automatic readAllWords(input string tag);
    for (int w = 0; w < MEMW; w++) begin
      drive(16'(2 * w), 1'b0, 1'b1, 1'b0, 16'h0, 2'd0, 16'h0);
      tick();
      chk(tag, rdResult, expWord(2 * w));
    end
  endtask

  initial begin
    #(8 * 200000);
    checks++; errors++;
    $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; accAddr = 0; accByte = 0; rdEn = 0; wrEn = 0;
    wrData = 0; extMode = 0; dstOld = 0; ptrIn = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R10 reset rdResult", rdResult, 16'h0);
    chk("R10 reset flags", {14'h0, rdValid, trapPulse}, 16'h0);
    @(negedge clk); rstN = 1'b1;
    tick();
    chk("R10 after release trapAddr", trapAddr, 16'h0);
    chk("R10 after release flags", {14'h0, rdValid, trapPulse}, 16'h0);

    // R1: aligned word writes and reads
    for (int w = 0; w < MEMW; w++) begin
      logic [15:0] d;
      d = 16'(w * 16'h0101) ^ 16'hA55A;
      drive(16'(2 * w), 1'b0, 1'b0, 1'b1, d, 2'd0, 16'h0);
      chk("R1 word we", {14'h0, memByteWe}, 16'h3);
      tick();
      shadow[2 * w] = d[7:0]; shadow[2 * w + 1] = d[15:8];
    end
    for (int w = 0; w < MEMW; w++) begin
      drive(16'(2 * w), 1'b0, 1'b1, 1'b0, 16'h0, 2'd0, 16'h0);
      tick();
      chk("R1 word read", rdResult, expWord(2 * w));
      chk("R1 rdValid/no trap", {14'h0, rdValid, trapPulse}, 16'h2);
    end

    // R2: byte writes on every address (odd ones first so neighbours differ)
    for (int a = 1; a < LIM; a += 2) begin
      logic [15:0] d;
      d = {8'hEE, 8'(a * 3 + 7)};
      drive(16'(a), 1'b1, 1'b0, 1'b1, d, 2'd0, 16'h0);
      chk("R2 byte we hi", {14'h0, memByteWe}, 16'h2);
      tick();
      shadow[a] = d[7:0];
      chk("R6 byte no trap", {15'h0, trapPulse}, 16'h0);
    end
    readAllWords("R2 low byte kept");
    for (int a = 0; a < LIM; a += 2) begin
      logic [15:0] d;
      d = {8'h11, 8'(a * 5 + 128)};
      drive(16'(a), 1'b1, 1'b0, 1'b1, d, 2'd0, 16'h0);
      chk("R2 byte we lo", {14'h0, memByteWe}, 16'h1);
      tick();
      shadow[a] = d[7:0];
    end
    readAllWords("R2 high byte kept");

    // R3 / R8: byte reads in every extension mode
    for (int e = 0; e < 4; e++) begin
      for (int a = 0; a < LIM; a++) begin
        logic [15:0] old;
        old = {8'(8'hC3 + a), 8'h5A};
        drive(16'(a), 1'b1, 1'b1, 1'b0, 16'h0, 2'(e), old);
        tick();
        chk((e == 1 || e == 2) ? "R8 byte extend" : "R3 byte merge", rdResult, expByte(a, 2'(e), old));
      end
    end
    // R8: word reads ignore extMode
    drive(16'h0006, 1'b0, 1'b1, 1'b0, 16'h0, 2'd2, 16'hFFFF);
    tick();
    chk("R8 word ignores ext", rdResult, expWord(6));

    // R4 / R6: misaligned word writes
    for (int a = 1; a < LIM; a += 2) begin
      drive(16'(a), 1'b0, 1'b0, 1'b1, 16'hDEAD, 2'd0, 16'h0);
      chk("R4 no we", {14'h0, memByteWe}, 16'h0);
      tick();
      chk("R6 trap on write", {15'h0, trapPulse}, 16'h1);
      chk("R6 trapAddr", trapAddr, 16'(a));
      drive(16'h0000, 1'b0, 1'b0, 1'b0, 16'h0, 2'd0, 16'h0);
      tick();
      chk("R6 single pulse", {15'h0, trapPulse}, 16'h0);
      chk("R6 trapAddr held", trapAddr, 16'(a));
    end
    readAllWords("R4 memory unchanged");

    // R5: misaligned word reads complete
    for (int a = 1; a < LIM; a += 2) begin
      drive(16'(a), 1'b0, 1'b1, 1'b0, 16'h0, 2'd0, 16'h0);
      tick();
      chk("R5 containing word", rdResult, expWord(a));
      chk("R5 valid and trap", {14'h0, rdValid, trapPulse}, 16'h3);
    end

    // R9: unimplemented region
    drive(16'(LIM), 1'b0, 1'b0, 1'b1, 16'hBEEF, 2'd0, 16'h0);
    chk("R9 write ignored we", {14'h0, memByteWe}, 16'h0);
    tick();
    drive(16'hFFFE, 1'b0, 1'b0, 1'b1, 16'hBEEF, 2'd0, 16'h0);
    chk("R9 write ignored we top", {14'h0, memByteWe}, 16'h0);
    tick();
    drive(16'h0101, 1'b1, 1'b0, 1'b1, 16'h00BB, 2'd0, 16'h0);
    chk("R9 byte write ignored", {14'h0, memByteWe}, 16'h0);
    tick();
    readAllWords("R9 no aliasing");
    drive(16'(LIM), 1'b0, 1'b1, 1'b0, 16'h0, 2'd0, 16'h0);
    tick();
    chk("R9 read zero", rdResult, 16'h0);
    drive(16'hFFFE, 1'b0, 1'b1, 1'b0, 16'h0, 2'd0, 16'h0);
    tick();
    chk("R9 read zero top", rdResult, 16'h0);
    drive(16'h0101, 1'b1, 1'b1, 1'b0, 16'h0, 2'd1, 16'h7777);
    tick();
    chk("R9 byte read zero", rdResult, 16'h0);

    // R11: read and write together
    drive(16'h0004, 1'b0, 1'b1, 1'b1, 16'h1234, 2'd0, 16'h0);
    chk("R11 write enables", {14'h0, memByteWe}, 16'h3);
    tick();
    shadow[4] = 8'h34; shadow[5] = 8'h12;
    chk("R11 no rdValid", {15'h0, rdValid}, 16'h0);
    drive(16'h0004, 1'b0, 1'b1, 1'b0, 16'h0, 2'd0, 16'h0);
    tick();
    chk("R11 write landed", rdResult, 16'h1234);

    // R7: pointer post-increment
    for (int i = 0; i < 256; i++) begin
      for (int b = 0; b < 2; b++) begin
        logic [15:0] p;
        p = (i == 255) ? 16'hFFFF : ((i == 254) ? 16'hFFFE : 16'(i * 257));
        @(negedge clk);
        ptrIn = p; accByte = 1'(b); rdEn = 0; wrEn = 0;
        #1;
        chk("R7 ptrNext", ptrNext, p + (b == 1 ? 16'd1 : 16'd2));
      end
    end

    drive(16'h0, 1'b0, 1'b0, 1'b0, 16'h0, 2'd0, 16'h0);
    tick();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule